// File: doc/BRIEF.md
# Smartcard Coupler Control Core

This block is the digital control core of a reader that sits between a host microcontroller and a smartcard connector. All host lines are sampled on a single system clock. An active-low chip select decides whether host signals reach the card. While it is low, the host reset line is forwarded to the card reset output. While it is high, the card-side signals are frozen at their last value.

The card clock comes from one of two host clock lines, chosen by a 3-bit configuration word. The first source is a synchronous clock line, which is gated and frozen by chip select like the reset line. The second is a free-running asynchronous clock, which can be divided by 1, 2 or 4. The host loads the configuration word by holding an active-low mode line low while it drops chip select. It then presents the word on its reset, data and synchronous clock lines, and raises chip select to capture it.

Card insertion is seen on an active-low detect input. This input passes through a two-flop synchronizer, and a falling edge asserts an interrupt. The interrupt is given as a level plus an output enable so that several couplers can share one wired-AND line. It is released by a rising edge of chip select or of power-on.

Top module: `sc_coupler_ctrl`

## Requirements
- R1: While chip select is low and the block is not in programming mode, `card_rst_o` takes the value of `host_rst_i` one clock later.
- R2: While chip select is high, `card_rst_o` keeps its value whatever `host_rst_i` does.
- R3: A falling chip select seen while `mode_n_i` is low enters programming mode. From that edge until programming ends, `card_rst_o` does not follow `host_rst_i`.
- R4: A falling chip select seen while `mode_n_i` is high does not enter programming mode. The following rising chip select leaves the configuration unchanged.
- R5: In programming mode, the rising chip select edge loads the word {host_rst_i, host_io_i, sync_clk_i} as bits 2, 1 and 0, and programming mode ends on that same edge.
- R6: With configuration bit 0 = 1, `card_clk_o` follows `sync_clk_i` one clock later while chip select is low, and it holds while chip select is high.
- R7: With configuration bit 0 = 0, `card_clk_o` is the asynchronous clock divided according to bits 2:1. The codes are 00 = /1 (passed straight through), 01 = /2, and 10 or 11 = /4.
- R8: A high-to-low transition of `det_n_i` drives `irq_o` low on the third rising clock edge after the change. `irq_oe_o` is high exactly while `irq_o` is low. A low-to-high transition of `det_n_i` does not assert the interrupt.
- R9: `irq_o` returns high one clock after a rising edge of `cs_n_i` or of `pwr_on_i`. If an insertion is recognised on the same clock, the insertion wins and `irq_o` stays low.
- R10: After reset, `card_rst_o` is 0, `irq_o` is 1, `irq_oe_o` is 0, and the configuration selects the asynchronous clock divided by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Host chip select, active low |
| pwr_on_i | input | 1 | Host power-on request |
| mode_n_i | input | 1 | Programming request, active low |
| host_rst_i | input | 1 | Host reset line, also configuration bit 2 |
| host_io_i | input | 1 | Host data line, used as configuration bit 1 |
| sync_clk_i | input | 1 | Synchronous clock line, also configuration bit 0 |
| async_clk_i | input | 1 | Free-running asynchronous clock source |
| det_n_i | input | 1 | Card detect, active low |
| card_rst_o | output | 1 | Reset to the card |
| card_clk_o | output | 1 | Clock to the card |
| irq_o | output | 1 | Interrupt level, low when a card was inserted |
| irq_oe_o | output | 1 | Interrupt output enable for wired-AND |

## Verification
The bench steps through all eight configuration words. For each word it counts card clock rising edges over a fixed run of 32 asynchronous periods, or over toggles of the synchronous line. These counts tell the /1, /2 and /4 ratios and the two sources apart, and show that the two /4 codes behave the same. The synchronous line is toggled once with chip select low and once with it high, which separates gating from passing through. The reset line is driven against chip select both in normal mode and in programming mode. A chip select cycle with the mode line high shows that it does not reprogram the block. For the interrupt, the bench drives insertion, removal, release by chip select, release by power-on, and an insertion that lands on the same clock as a release.

// File: rtl/sc_coupler_ctrl.sv
module sc_coupler_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic pwr_on_i,
  input  logic mode_n_i,
  input  logic host_rst_i,
  input  logic host_io_i,
  input  logic sync_clk_i,
  input  logic async_clk_i,
  input  logic det_n_i,
  output logic card_rst_o,
  output logic card_clk_o,
  output logic irq_o,
  output logic irq_oe_o
);
  localparam int CFG_W = 3;

  logic             cs_q, pwr_q, async_q, prog_q;
  logic             rst_q, sync_q, irq_q;
  logic [CFG_W-1:0] cfg_q;
  logic [DIV_W-1:0] div_cnt;
  logic [SYNC_STAGES:0] det_sh;

  wire cs_fall   = !cs_n_i && cs_q;
  wire cs_rise   = cs_n_i && !cs_q;
  wire pwr_rise  = pwr_on_i && !pwr_q;
  wire enter_prg = cs_fall && !mode_n_i;
  wire pass      = !cs_n_i && !prog_q && !enter_prg;
  wire insertion = det_sh[SYNC_STAGES] && !det_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      pwr_q   <= 1'b0;
      async_q <= 1'b0;
      det_sh  <= '1;
    end else begin
      cs_q    <= cs_n_i;
      pwr_q   <= pwr_on_i;
      async_q <= async_clk_i;
      det_sh  <= {det_sh[SYNC_STAGES-1:0], det_n_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b0;
      cfg_q  <= '0;
    end else if (prog_q && cs_rise) begin
      prog_q <= 1'b0;
      cfg_q  <= {host_rst_i, host_io_i, sync_clk_i};
    end else if (enter_prg) begin
      prog_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b0;
      sync_q <= 1'b0;
    end else if (pass) begin
      rst_q  <= host_rst_i;
      sync_q <= sync_clk_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      div_cnt <= '0;
    else if (async_clk_i && !async_q) div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   irq_q <= 1'b1;
    else if (insertion)           irq_q <= 1'b0;
    else if (cs_rise || pwr_rise) irq_q <= 1'b1;
  end

  logic async_sel;
  always_comb begin
    case (cfg_q[2:1])
      2'b00:   async_sel = async_clk_i;
      2'b01:   async_sel = div_cnt[0];
      default: async_sel = div_cnt[1];
    endcase
  end

  assign card_clk_o = cfg_q[0] ? sync_q : async_sel;
  assign card_rst_o = rst_q;
  assign irq_o      = irq_q;
  assign irq_oe_o   = !irq_q;

  p_rst_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> $stable(card_rst_o));
  p_prog_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !mode_n_i) |=> prog_q);
  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_q && cs_rise) |=> $stable(cfg_q));
  p_prog_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_q && cs_rise) |=> !prog_q);
  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    insertion |=> !irq_o);
  p_irq_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !cs_rise && !pwr_rise) |=> !irq_o);
endmodule

// File: tb/sim_sc_coupler_ctrl.sv
module sim_sc_coupler_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, pwr_on = 1'b0, mode_n = 1'b1;
  logic host_rst = 1'b0, host_io = 1'b0, sync_clk = 1'b0, async_clk = 1'b0;
  logic det_n = 1'b1;
  logic card_rst, card_clk, irq, irq_oe;

  int checks = 0, fails = 0, rises = 0;
  logic prev_clk = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sc_coupler_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .pwr_on_i(pwr_on),
    .mode_n_i(mode_n), .host_rst_i(host_rst), .host_io_i(host_io),
    .sync_clk_i(sync_clk), .async_clk_i(async_clk), .det_n_i(det_n),
    .card_rst_o(card_rst), .card_clk_o(card_clk), .irq_o(irq), .irq_oe_o(irq_oe)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (card_clk && !prev_clk) rises++;
    prev_clk = card_clk;
  endtask

  task automatic program_cfg(logic [2:0] w);
    @(negedge clk);
    mode_n = 1'b0; cs_n = 1'b0;
    host_rst = w[2]; host_io = w[1]; sync_clk = w[0];
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    mode_n = 1'b1; host_rst = 1'b0; host_io = 1'b0; sync_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic count_async(int periods);
    rises = 0; prev_clk = card_clk;
    for (int i = 0; i < periods; i++) begin
      async_clk = 1'b1; repeat (3) tick();
      async_clk = 1'b0; repeat (3) tick();
    end
    repeat (3) tick();
  endtask

  task automatic count_sync(int toggles);
    rises = 0; prev_clk = card_clk;
    for (int i = 0; i < toggles; i++) begin
      sync_clk = 1'b1; repeat (2) tick();
      sync_clk = 1'b0; repeat (2) tick();
    end
    repeat (2) tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R10 card_rst after reset", card_rst, 0);
    check("R10 irq after reset", irq, 1);
    check("R10 irq_oe after reset", irq_oe, 0);
    count_async(32);
    check("R10 default async /1 edges", rises, 32);

    cs_n = 1'b0; host_rst = 1'b1;
    tick();
    check("R1 card_rst follows host high", card_rst, 1);
    host_rst = 1'b0; tick();
    check("R1 card_rst follows host low", card_rst, 0);
    host_rst = 1'b1; tick();
    check("R1 card_rst follows host high again", card_rst, 1);

    cs_n = 1'b1; host_rst = 1'b0;
    repeat (3) tick();
    check("R2 card_rst held while cs high", card_rst, 1);

    @(negedge clk);
    mode_n = 1'b0; cs_n = 1'b0; host_rst = 1'b0;
    tick();
    check("R3 no pass on programming entry", card_rst, 1);
    host_rst = 1'b0; repeat (2) tick();
    check("R3 no pass during programming", card_rst, 1);
    host_rst = 1'b0; host_io = 1'b0; sync_clk = 1'b0;
    cs_n = 1'b1; repeat (2) tick();
    mode_n = 1'b1; tick();
    count_async(32);
    check("R5 word 000 gives async /1", rises, 32);

    @(negedge clk);
    cs_n = 1'b0; host_rst = 1'b1; host_io = 1'b1; sync_clk = 1'b1;
    repeat (2) tick();
    cs_n = 1'b1; repeat (2) tick();
    host_rst = 1'b0; host_io = 1'b0; sync_clk = 1'b0; tick();
    count_async(32);
    check("R4 cs cycle with mode high keeps config", rises, 32);

    for (int w = 0; w < 8; w++) begin
      program_cfg(3'(w));
      if (w % 2 == 1) begin
        @(negedge clk); cs_n = 1'b0; repeat (2) tick();
        count_sync(8);
        check($sformatf("R6 word %0d sync passes with cs low", w), rises, 8);
        cs_n = 1'b1; repeat (2) tick();
        count_sync(8);
        check($sformatf("R6 word %0d sync frozen with cs high", w), rises, 0);
      end else begin
        count_async(32);
        check($sformatf("R7 word %0d async divided edges", w), rises,
              32 / ((w / 2 == 0) ? 1 : (w / 2 == 1) ? 2 : 4));
      end
    end

    program_cfg(3'b000);
    @(negedge clk); pwr_on = 1'b1; tick(); pwr_on = 1'b0; tick();
    det_n = 1'b0; repeat (2) tick();
    check("R8 irq not yet low after two edges", irq, 1);
    tick();
    check("R8 irq low after insertion", irq, 0);
    check("R8 irq_oe high while irq low", irq_oe, 1);
    cs_n = 1'b0; repeat (2) tick();
    cs_n = 1'b1; tick();
    check("R9 irq released by cs rise", irq, 1);
    check("R9 irq_oe released by cs rise", irq_oe, 0);

    det_n = 1'b1; repeat (4) tick();
    check("R8 removal leaves irq high", irq, 1);

    det_n = 1'b0; repeat (3) tick();
    check("R8 second insertion", irq, 0);
    pwr_on = 1'b1; tick();
    check("R9 irq released by power-on rise", irq, 1);
    pwr_on = 1'b0;
    det_n = 1'b1; repeat (4) tick();

    cs_n = 1'b0; tick();
    det_n = 1'b0; repeat (2) tick();
    cs_n = 1'b1; tick();
    check("R9 insertion wins over cs rise", irq, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule